// File: doc/BRIEF.md
# Two-Path RAM Access Arbiter

This block sits in front of a banked, single-ported on-chip RAM and decides, cycle by cycle, who may use it. Two groups of masters reach the RAM. The main system bus carries four masters: a debug master, a serial-debug master, a DMA engine and the CPU. A separate side path carries two capture masters, A and B, that only ever write. The RAM is split into 16-Kbyte windows. Each window is a bank that can serve one main-bus access and one side-path write in the same cycle, provided the two fall in different windows.

On the main bus a fixed order picks one winner per cycle: debug, then serial-debug, then DMA, then CPU. Debug and serial-debug share the top level, and debug wins a tie. The side path picks A over B. Normally the side path never waits for the main bus. When a capture master targets the same 16-Kbyte window as the main-bus winner in that cycle, the main master wins, because every main master ranks above both capture masters. That capture master is stalled. The other capture master may still use the side port if its own window is free.

A grant is combinational and marks the cycle in which the RAM port carries that master's access. A master without a grant sees a stall and keeps its request, address and data stable. Read data from the RAM arrives one cycle after the access and is flagged valid only to the main master that issued the read.

Top module: `ram_arb_top`

## Requirements
- R1: Main-bus priority is fixed by index, lowest index first: 0 debug, 1 serial-debug, 2 DMA, 3 CPU. When any main master requests, exactly one main grant is asserted, and it goes to the lowest requesting index.
- R2: In the cycle of a main grant, ram_m_en is 1 and ram_m_addr, ram_m_we and ram_m_wdata carry that master's values. With no main grant, ram_m_en is 0. A grant is never given to a master that is not requesting.
- R3: Between the capture masters, index 0 (A) is served before index 1 (B) when neither conflicts.
- R4: The window of an address is its bits from bit 14 upward. A side write whose window differs from the main winner's window is granted in the same cycle as the main access.
- R5: A capture master whose window equals the main winner's window in that cycle is not granted. The main access proceeds.
- R6: When A is blocked by a window conflict and B requests a different window, B is granted in that cycle.
- R7: The side port only writes. In the cycle of a side grant, ram_s_en is 1 and ram_s_addr and ram_s_wdata carry the granted capture master's values. At most one side grant is asserted per cycle.
- R8: One cycle after a main read grant (we = 0), m_rvalid is asserted for that master only, and m_rdata equals ram_m_rdata. After a main write, or when there is no main grant, m_rvalid is all zero.
- R9: While rst is high, no grant is issued and no port is enabled. m_rvalid is zero in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 4 | Main-bus requests, index = priority |
| m_we | input | 4 | Main-bus write enables |
| m_addr | input | 4x16 | Main-bus byte addresses |
| m_wdata | input | 4x32 | Main-bus write data |
| m_gnt | output | 4 | Main-bus grants (low = stall) |
| m_rvalid | output | 4 | Read data valid, one bit per main master |
| m_rdata | output | 32 | Read data returned to main masters |
| s_req | input | 2 | Capture-master write requests |
| s_addr | input | 2x16 | Capture-master addresses |
| s_wdata | input | 2x32 | Capture-master write data |
| s_gnt | output | 2 | Capture-master grants (low = stall) |
| ram_m_en | output | 1 | Main RAM port enable |
| ram_m_we | output | 1 | Main RAM port write enable |
| ram_m_addr | output | 16 | Main RAM port address |
| ram_m_wdata | output | 32 | Main RAM port write data |
| ram_m_rdata | input | 32 | Main RAM port read data, one cycle after enable |
| ram_s_en | output | 1 | Side RAM port write enable |
| ram_s_addr | output | 16 | Side RAM port address |
| ram_s_wdata | output | 32 | Side RAM port write data |

## Verification
The assertions check several properties on every cycle. Grants on each path are one-hot or zero. No master without a request is granted. Any main request produces a main grant. The two RAM ports are never both enabled on the same window. A main read is always followed by exactly one valid flag, and a write by none. The assertions cannot show that the winner is the right master, or that a capture master B takes the side port when A is blocked. The bench shows these by sweeping every request pattern on both paths against every window placement. It also compares each grant, port field and returned read flag with values it works out from the priority order.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;

    // Main-bus master indices; the index is also the arbitration rank.
    typedef enum logic [1:0] {
        MST_DEBUG  = 2'd0,
        MST_SDEBUG = 2'd1,
        MST_DMA    = 2'd2,
        MST_CPU    = 2'd3
    } main_id_e;

    localparam int unsigned MAIN_COUNT = 4;
    localparam int unsigned SIDE_COUNT = 2;
    localparam int unsigned ADDR_BITS  = 16;
    localparam int unsigned DATA_BITS  = 32;
    localparam int unsigned WIN_SHIFT  = 14;   // 16-Kbyte windows

    // One RAM access as presented to a port.
    typedef struct packed {
        logic                 en;
        logic                 we;
        logic [ADDR_BITS-1:0] addr;
        logic [DATA_BITS-1:0] wdata;
    } ram_req_t;

    // True when two addresses fall in the same 16-Kbyte window.
    function automatic logic same_window(input logic [31:0] a, input logic [31:0] b);
        return (a >> WIN_SHIFT) == (b >> WIN_SHIFT);
    endfunction

endpackage

// File: rtl/ram_arb_prio_pick.sv
module ram_arb_prio_pick #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N:0] taken;
    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_rank
        assign gnt[i]       = req[i] & ~taken[i];
        assign taken[i + 1] = taken[i] | req[i];
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    p_gnt_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
    p_work_conserving_r1: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|gnt));
endmodule

// File: rtl/ram_arb_side_pick.sv
module ram_arb_side_pick
    import ram_arb_pkg::*;
#(
    parameter int unsigned NS = SIDE_COUNT,
    parameter int unsigned AW = ADDR_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NS-1:0]         s_req,
    input  logic [NS-1:0][AW-1:0] s_addr,
    input  logic                  main_busy,
    input  logic [AW-1:0]         main_addr,
    output logic [NS-1:0]         s_gnt
);
    logic [NS-1:0] clash;
    logic [NS-1:0] eligible;

    for (genvar j = 0; j < NS; j++) begin : g_clash
        assign clash[j]    = main_busy & same_window(32'(s_addr[j]), 32'(main_addr));
        assign eligible[j] = s_req[j] & ~clash[j];
    end

    ram_arb_prio_pick #(.N(NS)) u_pick (
        .clk (clk),
        .rst (rst),
        .req (eligible),
        .gnt (s_gnt)
    );

    p_clash_stalls_r5: assert property (@(posedge clk) disable iff (rst)
        (s_gnt & clash) == '0);
endmodule

// File: rtl/ram_arb_rd_track.sv
module ram_arb_rd_track #(
    parameter int unsigned NM = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NM-1:0] rd_gnt,
    output logic [NM-1:0] rvalid
);
    always_ff @(posedge clk) begin
        if (rst) rvalid <= '0;
        else     rvalid <= rd_gnt;
    end

    p_rvalid_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rvalid));
endmodule

// File: rtl/ram_arb_top.sv
module ram_arb_top
    import ram_arb_pkg::*;
#(
    parameter int unsigned NM = MAIN_COUNT,
    parameter int unsigned NS = SIDE_COUNT,
    parameter int unsigned AW = ADDR_BITS,
    parameter int unsigned DW = DATA_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NM-1:0]         m_req,
    input  logic [NM-1:0]         m_we,
    input  logic [NM-1:0][AW-1:0] m_addr,
    input  logic [NM-1:0][DW-1:0] m_wdata,
    output logic [NM-1:0]         m_gnt,
    output logic [NM-1:0]         m_rvalid,
    output logic [DW-1:0]         m_rdata,
    input  logic [NS-1:0]         s_req,
    input  logic [NS-1:0][AW-1:0] s_addr,
    input  logic [NS-1:0][DW-1:0] s_wdata,
    output logic [NS-1:0]         s_gnt,
    output logic                  ram_m_en,
    output logic                  ram_m_we,
    output logic [AW-1:0]         ram_m_addr,
    output logic [DW-1:0]         ram_m_wdata,
    input  logic [DW-1:0]         ram_m_rdata,
    output logic                  ram_s_en,
    output logic [AW-1:0]         ram_s_addr,
    output logic [DW-1:0]         ram_s_wdata
);
    logic [NM-1:0] m_req_live;
    logic [NS-1:0] s_req_live;

    assign m_req_live = m_req & {NM{~rst}};
    assign s_req_live = s_req & {NS{~rst}};

    // Main-bus winner.
    ram_arb_prio_pick #(.N(NM)) u_main_pick (
        .clk (clk),
        .rst (rst),
        .req (m_req_live),
        .gnt (m_gnt)
    );

    // Main port mux (one-hot select).
    always_comb begin
        ram_m_en    = |m_gnt;
        ram_m_we    = 1'b0;
        ram_m_addr  = '0;
        ram_m_wdata = '0;
        for (int i = 0; i < NM; i++) begin
            if (m_gnt[i]) begin
                ram_m_we    = ram_m_we    | m_we[i];
                ram_m_addr  = ram_m_addr  | m_addr[i];
                ram_m_wdata = ram_m_wdata | m_wdata[i];
            end
        end
    end

    // Side path, aware of the main winner's window.
    ram_arb_side_pick #(.NS(NS), .AW(AW)) u_side_pick (
        .clk       (clk),
        .rst       (rst),
        .s_req     (s_req_live),
        .s_addr    (s_addr),
        .main_busy (ram_m_en),
        .main_addr (ram_m_addr),
        .s_gnt     (s_gnt)
    );

    always_comb begin
        ram_s_en    = |s_gnt;
        ram_s_addr  = '0;
        ram_s_wdata = '0;
        for (int j = 0; j < NS; j++) begin
            if (s_gnt[j]) begin
                ram_s_addr  = ram_s_addr  | s_addr[j];
                ram_s_wdata = ram_s_wdata | s_wdata[j];
            end
        end
    end

    // Read return.
    ram_arb_rd_track #(.NM(NM)) u_rd_track (
        .clk    (clk),
        .rst    (rst),
        .rd_gnt (m_gnt & ~m_we),
        .rvalid (m_rvalid)
    );
    assign m_rdata = ram_m_rdata;

    p_ports_disjoint_r5: assert property (@(posedge clk) disable iff (rst)
        (ram_m_en && ram_s_en) |-> !same_window(32'(ram_m_addr), 32'(ram_s_addr)));
    p_read_returns_r8: assert property (@(posedge clk) disable iff (rst)
        (ram_m_en && !ram_m_we) |=> ($countones(m_rvalid) == 1));
    p_write_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (!ram_m_en || ram_m_we) |=> (m_rvalid == '0));
    p_side_one_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_gnt));
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |-> (!ram_m_en && !ram_s_en));
endmodule

// File: tb/ram_arb_top_tb.sv
module ram_arb_top_tb;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NM = 4;
    localparam int unsigned NS = 2;
    localparam int unsigned AW = 16;
    localparam int unsigned DW = 32;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NM-1:0]         m_req = '0;
    logic [NM-1:0]         m_we = '0;
    logic [NM-1:0][AW-1:0] m_addr = '0;
    logic [NM-1:0][DW-1:0] m_wdata = '0;
    logic [NM-1:0]         m_gnt;
    logic [NM-1:0]         m_rvalid;
    logic [DW-1:0]         m_rdata;
    logic [NS-1:0]         s_req = '0;
    logic [NS-1:0][AW-1:0] s_addr = '0;
    logic [NS-1:0][DW-1:0] s_wdata = '0;
    logic [NS-1:0]         s_gnt;
    logic                  ram_m_en, ram_m_we, ram_s_en;
    logic [AW-1:0]         ram_m_addr, ram_s_addr;
    logic [DW-1:0]         ram_m_wdata, ram_s_wdata;
    logic [DW-1:0]         ram_m_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ram_arb_top u_dut (
        .clk(clk), .rst(rst),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_gnt(m_gnt), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
        .s_req(s_req), .s_addr(s_addr), .s_wdata(s_wdata), .s_gnt(s_gnt),
        .ram_m_en(ram_m_en), .ram_m_we(ram_m_we), .ram_m_addr(ram_m_addr),
        .ram_m_wdata(ram_m_wdata), .ram_m_rdata(ram_m_rdata),
        .ram_s_en(ram_s_en), .ram_s_addr(ram_s_addr), .ram_s_wdata(ram_s_wdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NM-1:0] exp_rv;
        logic [NM-1:0] exp_mg;
        logic [NS-1:0] exp_sg;
        int            win_main;
        int            mw;
        logic [AW-1:0] exp_addr;
        logic          exp_we;
        logic [DW-1:0] exp_wd;
        bit            conf_a, conf_b, elig_a, elig_b;
        string         stag;
        int            iter;

        // R9: reset holds everything idle even with all requests up
        m_req = '1;
        s_req = '1;
        for (int c = 0; c < 3; c++) @(negedge clk);
        chk(m_gnt == '0 && s_gnt == '0, "R9 grants in reset", {m_gnt, s_gnt}, 0);
        chk(!ram_m_en && !ram_s_en, "R9 ports in reset", {ram_m_en, ram_s_en}, 0);
        m_req = '0;
        s_req = '0;
        rst = 1'b0;
        @(negedge clk);
        chk(m_rvalid == '0, "R9 rvalid after reset", m_rvalid, 0);

        exp_rv = '0;
        iter   = 0;
        for (int mr = 0; mr < 16; mr++)
        for (int sr = 0; sr < 4; sr++)
        for (int k = 0; k < 4; k++)
        for (int wa = 0; wa < 4; wa++)
        for (int wb = 0; wb < 4; wb++) begin
            // registered read return from the previous combination (R8)
            chk(m_rvalid == exp_rv, "R8 rvalid", m_rvalid, exp_rv);
            if (exp_rv != '0)
                chk(m_rdata == ram_m_rdata, "R8 rdata", m_rdata, ram_m_rdata);

            iter++;
            ram_m_rdata = 32'hC0DE_0000 + 32'(iter);
            m_req = 4'(mr);
            s_req = 2'(sr);
            m_we  = k[0] ? 4'b1010 : 4'b0101;
            for (int i = 0; i < NM; i++) begin
                win_main   = (i + k) % 4;
                m_addr[i]  = {2'(win_main), 14'(i * 16 + k)};
                m_wdata[i] = 32'h1000_0000 * 32'(i + 1) + 32'(iter);
            end
            s_addr[0]  = {2'(wa), 14'h0100};
            s_addr[1]  = {2'(wb), 14'h0200};
            s_wdata[0] = 32'hAAAA_0000 + 32'(iter);
            s_wdata[1] = 32'hBBBB_0000 + 32'(iter);
            #1;

            // expected main winner: lowest requesting index
            exp_mg = '0;
            mw     = -1;
            for (int i = NM - 1; i >= 0; i--) if (mr[i]) mw = i;
            if (mw >= 0) exp_mg[mw] = 1'b1;
            chk(m_gnt == exp_mg, "R1 main grant", m_gnt, exp_mg);
            chk(ram_m_en == (mw >= 0), "R2 main enable", ram_m_en, mw >= 0);
            if (mw >= 0) begin
                exp_addr = {2'((mw + k) % 4), 14'(mw * 16 + k)};
                exp_we   = k[0] ? 1'(mw % 2) : 1'(1 - mw % 2);
                exp_wd   = 32'h1000_0000 * 32'(mw + 1) + 32'(iter);
                chk(ram_m_addr == exp_addr && ram_m_we == exp_we && ram_m_wdata == exp_wd,
                    "R2 main port fields", {ram_m_we, ram_m_addr, ram_m_wdata},
                    {exp_we, exp_addr, exp_wd});
            end

            // expected side grant
            conf_a = (mw >= 0) && (wa == (mw + k) % 4);
            conf_b = (mw >= 0) && (wb == (mw + k) % 4);
            elig_a = sr[0] && !conf_a;
            elig_b = sr[1] && !conf_b;
            exp_sg = elig_a ? 2'b01 : (elig_b ? 2'b10 : 2'b00);
            if (sr[0] && conf_a && elig_b)      stag = "R6 B past blocked A";
            else if ((sr[0] && conf_a) || (sr[1] && conf_b)) stag = "R5 window clash";
            else if (sr == 3)                   stag = "R3 A before B";
            else                                stag = "R4 side concurrent";
            chk(s_gnt == exp_sg, stag, s_gnt, exp_sg);
            chk(ram_s_en == (exp_sg != 0), "R7 side enable", ram_s_en, exp_sg != 0);
            if (exp_sg == 2'b01)
                chk(ram_s_addr == s_addr[0] && ram_s_wdata == s_wdata[0], "R7 side fields A",
                    {ram_s_addr, ram_s_wdata}, {s_addr[0], s_wdata[0]});
            if (exp_sg == 2'b10)
                chk(ram_s_addr == s_addr[1] && ram_s_wdata == s_wdata[1], "R7 side fields B",
                    {ram_s_addr, ram_s_wdata}, {s_addr[1], s_wdata[1]});

            exp_rv = '0;
            if (mw >= 0 && !exp_we) exp_rv[mw] = 1'b1;
            @(negedge clk);
        end
        chk(m_rvalid == exp_rv, "R8 final rvalid", m_rvalid, exp_rv);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule